// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Error Status

This block receives asynchronous serial characters on a single line that rests high. A free-running enable, pulsed at sixteen times the bit rate, paces every decision. The block finds each start edge and checks it again at the middle of the bit. It then samples eight data bits, an optional parity bit and one stop bit at their bit centres. Each finished character goes into a two-slot queue. Its frame-error and parity-error results go into the same slot, so each result stays with the character it describes.

The host sees the oldest queued character on a data output, together with a valid signal and three status flags: frame error, parity error and overrun. These flags always describe the character at the head. They do not change until the host pops that character. A one-cycle pop strobe moves the data and the flags to the next slot together. If both slots are full, a third character can wait in the shift register. When a fourth start edge arrives in that state, the waiting character is dropped and an overrun mark is placed on the next character that enters the queue. No error of any kind stops reception.

The frame state machine has seven states:
- IDLE waits for a falling edge.
- START_CHK re-checks the start bit at mid-bit. It goes to IDLE if the line is high and to DATA if the line is low.
- DATA samples eight bits. It then goes to PARITY when parity is on, or to STOP when it is off.
- PARITY samples one bit and goes to STOP.
- STOP samples the stop bit. It pushes the character into the queue and goes to IDLE, or to WAIT_HIGH if the stop bit was low. If the queue is full it goes to HOLD instead.
- HOLD keeps the finished character. When room appears it pushes the character and leaves for START_CHK, IDLE or WAIT_HIGH. If a new start edge arrives while the queue is still full, it drops the character and goes to START_CHK.
- WAIT_HIGH returns to IDLE once the line is sampled high.

Top module: `uart_rx_errflag`

## Requirements
- R1: The line rests high. A start is a high-to-low change of the line, seen on a tick. If the line is sampled high at the middle of the start bit, the start is treated as a glitch, no character is produced and the receiver goes back to IDLE.
- R2: Eight data bits are sampled at bit centres, least significant bit first. They appear unchanged on `rx_data`.
- R3: Parity enable and odd/even select are captured when the start bit is confirmed. With parity on, a parity bit follows the data. In even mode the count of ones in the data and parity bit together must be even, and in odd mode it must be odd; otherwise `st_par_err` is set for that character. With parity off, no parity bit is expected and `st_par_err` stays 0.
- R4: `st_frame_err` is 1 for a character whose stop bit was sampled low, and 0 when the stop bit was sampled high.
- R5: After a character with a low stop bit, a line held low produces no further characters until the line has gone high and fallen again.
- R6: The queue holds two complete characters in arrival order. `rx_valid` is 1 while the queue is not empty. The data and all three flags at the head stay unchanged until a pop, and a pop moves them to the next character.
- R7: A start edge seen while both slots are full and a finished character waits in the shift register is an overrun. The waiting character is dropped, the queued characters are kept, and `st_overrun` is 1 on the next character that enters the queue.
- R8: After a frame, parity or overrun error, later characters are received correctly, with their flags clear.
- R9: After reset, and whenever the queue is empty, `rx_valid`, `rx_data` and all three flags are 0.
- R10: A pop while the queue is empty has no effect.
- R11: A character waiting in the shift register enters the queue, with no overrun mark, as soon as a pop makes room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial line, rests high |
| os_tick | input | 1 | Sample enable at 16 times the bit rate |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_pop | input | 1 | One-cycle strobe that removes the head character |
| rx_data | output | 8 | Head character, 0 when empty |
| rx_valid | output | 1 | Queue holds at least one character |
| st_frame_err | output | 1 | Head character had a low stop bit |
| st_par_err | output | 1 | Head character failed its parity check |
| st_overrun | output | 1 | At least one character was dropped just before the head character |

## Verification
The assertions assume that `rd_pop` is a plain strobe that the host may raise in any cycle, including when the queue is empty. They also assume that the serial line changes only between host actions and never in step with the clock edge. The bench holds each bit on the line for exactly sixteen ticks, with a tick on every second cycle. Every edge of `rx_line` and `rd_pop` falls on a negative clock edge. Frames are sent only after the previous frame's stop bit has been held for its full length, except in the glitch and stuck-low scenarios, which break this framing on purpose.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int RX_DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START_CHK,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [RX_DATA_W-1:0] data;
        logic                 ferr;
        logic                 perr;
        logic                 ovr;
    } rx_entry_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic tick,
    output logic line_s,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign line_s = chain_q[STAGES-1];

    // previous line level, advanced only on sample ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= line_s;
    end

    assign fall = tick && prev_q && !line_s;

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line_s,
    input  logic      fall,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      can_push,
    output logic      push,
    output rx_entry_t push_entry,
    output logic      ovr_pending
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int BIT_W = $clog2(RX_DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RX_DATA_W - 1);

    rx_state_e            state_q, state_n;
    logic [CNT_W-1:0]     cnt_q;
    logic [BIT_W-1:0]     bidx_q;
    logic [RX_DATA_W-1:0] shreg_q;
    logic                 par_on_q, par_odd_q;
    logic                 perr_q, ferr_q, ovr_q;

    logic at_mid, at_end;
    assign at_mid = tick && (cnt_q == MID_CNT);
    assign at_end = tick && (cnt_q == LAST_CNT);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (fall) state_n = RX_START_CHK;
            end
            RX_START_CHK: begin
                if (at_mid) state_n = line_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (at_end && bidx_q == LAST_BIT)
                    state_n = par_on_q ? RX_PARITY : RX_STOP;
            end
            RX_PARITY: begin
                if (at_end) state_n = RX_STOP;
            end
            RX_STOP: begin
                if (at_end) begin
                    if (!can_push)    state_n = RX_HOLD;
                    else if (!line_s) state_n = RX_WAIT_HIGH;
                    else              state_n = RX_IDLE;
                end
            end
            RX_HOLD: begin
                if (can_push) begin
                    if (fall)        state_n = RX_START_CHK;
                    else if (ferr_q) state_n = RX_WAIT_HIGH;
                    else             state_n = RX_IDLE;
                end else if (fall) begin
                    state_n = RX_START_CHK;
                end
            end
            RX_WAIT_HIGH: begin
                if (tick && line_s) state_n = RX_IDLE;
            end
            default: state_n = RX_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            bidx_q    <= '0;
            shreg_q   <= '0;
            par_on_q  <= 1'b0;
            par_odd_q <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            state_q <= state_n;
            if (push) ovr_q <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (fall) cnt_q <= '0;
                end
                RX_START_CHK: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (at_mid && !line_s) begin
                        cnt_q     <= '0;
                        bidx_q    <= '0;
                        perr_q    <= 1'b0;
                        par_on_q  <= par_en;
                        par_odd_q <= par_odd;
                    end
                end
                RX_DATA: begin
                    if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
                    if (at_end) begin
                        shreg_q <= {line_s, shreg_q[RX_DATA_W-1:1]};
                        bidx_q  <= bidx_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
                    if (at_end) perr_q <= (^shreg_q) ^ line_s ^ par_odd_q;
                end
                RX_STOP: begin
                    if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
                    if (at_end) ferr_q <= !line_s;
                end
                RX_HOLD: begin
                    if (fall) cnt_q <= '0;
                    if (fall && !can_push) ovr_q <= 1'b1;
                end
                RX_WAIT_HIGH: begin
                    cnt_q <= '0;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        push            = 1'b0;
        push_entry.data = shreg_q;
        push_entry.ferr = ferr_q;
        push_entry.perr = perr_q;
        push_entry.ovr  = ovr_q;
        if (state_q == RX_STOP) begin
            push            = at_end && can_push;
            push_entry.ferr = !line_s;
        end else if (state_q == RX_HOLD) begin
            push = can_push;
        end
    end

    assign ovr_pending = ovr_q;

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  rx_entry_t                      push_entry,
    input  logic                           pop,
    output rx_entry_t                      head,
    output logic                           not_empty,
    output logic                           can_push,
    output logic [$clog2(DEPTH+1)-1:0]     occ
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rx_entry_t        slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] occ_q;
    logic             do_pop;

    assign do_pop    = pop && (occ_q != '0);
    assign can_push  = (occ_q != FULL_CNT) || do_pop;
    assign not_empty = (occ_q != '0);
    assign head      = slot_q[rd_q];
    assign occ       = occ_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slot_q[g] <= '0;
                else if (push && wr_q == PTR_W'(g))
                    slot_q[g] <= push_entry;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push)   wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            if (do_pop) rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            if (push && !do_pop)      occ_q <= occ_q + 1'b1;
            else if (!push && do_pop) occ_q <= occ_q - 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_errflag.sv
module uart_rx_errflag
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 os_tick,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rd_pop,
    output logic [RX_DATA_W-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 st_frame_err,
    output logic                 st_par_err,
    output logic                 st_overrun
);

    localparam int OCC_W = $clog2(FIFO_DEPTH + 1);

    logic             line_s, line_fall;
    logic             rx_push, fifo_room, ovr_pending;
    rx_entry_t        new_entry, head_entry;
    logic [OCC_W-1:0] fifo_occ;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .tick    (os_tick),
        .line_s  (line_s),
        .fall    (line_fall)
    );

    rx_frame_fsm #(.OS_RATE(OS_RATE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .line_s      (line_s),
        .fall        (line_fall),
        .par_en      (par_en),
        .par_odd     (par_odd),
        .can_push    (fifo_room),
        .push        (rx_push),
        .push_entry  (new_entry),
        .ovr_pending (ovr_pending)
    );

    rx_char_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_push),
        .push_entry (new_entry),
        .pop        (rd_pop),
        .head       (head_entry),
        .not_empty  (rx_valid),
        .can_push   (fifo_room),
        .occ        (fifo_occ)
    );

    assign rx_data      = rx_valid ? head_entry.data : '0;
    assign st_frame_err = rx_valid && head_entry.ferr;
    assign st_par_err   = rx_valid && head_entry.perr;
    assign st_overrun   = rx_valid && head_entry.ovr;

endmodule

// File: rtl/uart_rx_errflag_chk.sv
module uart_rx_errflag_chk #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_pop,
    input logic                       rx_valid,
    input logic [7:0]                 rx_data,
    input logic                       st_frame_err,
    input logic                       st_par_err,
    input logic                       st_overrun,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic                       push,
    input logic                       ovr_pend
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_CNT)
        else $error("queue occupancy above depth");

    p_head_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_pop) |=> (rx_valid && $stable(rx_data) && $stable(st_frame_err)
                                   && $stable(st_par_err) && $stable(st_overrun)))
        else $error("head changed without a pop");

    p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && push) |=> rx_valid)
        else $error("push into empty queue not visible");

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(1) && rd_pop && !push) |=> !rx_valid)
        else $error("last pop did not empty the queue");

    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && rd_pop && !push) |=> (!rx_valid && occ == '0))
        else $error("pop on empty queue changed state");

    p_ovr_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_pend) |-> (occ == FULL_CNT))
        else $error("overrun raised with room in the queue");

endmodule

bind uart_rx_errflag uart_rx_errflag_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_pop       (rd_pop),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .st_frame_err (st_frame_err),
    .st_par_err   (st_par_err),
    .st_overrun   (st_overrun),
    .occ          (fifo_occ),
    .push         (rx_push),
    .ovr_pend     (ovr_pending)
);

// File: tb/uart_rx_errflag_test.sv
`timescale 1ns/1ps
module uart_rx_errflag_test;

    localparam int BIT_CYC = 32;   // 16 ticks, one tick every 2 cycles
    localparam int WD_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst_n, rx_line, os_tick, par_en, par_odd, rd_pop;
    logic [7:0] rx_data;
    logic       rx_valid, st_frame_err, st_par_err, st_overrun;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;

    always #4 clk = ~clk;

    uart_rx_errflag uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .par_en(par_en), .par_odd(par_odd), .rd_pop(rd_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .st_frame_err(st_frame_err),
        .st_par_err(st_par_err), .st_overrun(st_overrun)
    );

    initial begin
        os_tick = 1'b0;
        forever @(negedge clk) os_tick = ~os_tick;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog expired: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check_head(input string req, input bit ev, input logic [7:0] ed,
                              input bit efe, input bit epe, input bit eov);
        checks++;
        if ({rx_valid, rx_data, st_frame_err, st_par_err, st_overrun} !==
            {ev, ed, efe, epe, eov}) begin
            failures++;
            $display("FAIL %s: got v=%0b d=%02h fe=%0b pe=%0b ov=%0b, expected v=%0b d=%02h fe=%0b pe=%0b ov=%0b",
                     req, rx_valid, rx_data, st_frame_err, st_par_err, st_overrun,
                     ev, ed, efe, epe, eov);
        end
    endtask

    task automatic send_bit(input bit v);
        rx_line = v;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit use_par, input bit odd,
                              input bit flip_par, input bit stop_v);
        par_en  = use_par;
        par_odd = odd;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (use_par) send_bit((^d) ^ odd ^ flip_par);
        send_bit(stop_v);
        send_bit(1'b1);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic t_reset();
        check_head("R9 reset state", 0, 8'h00, 0, 0, 0);
    endtask

    task automatic t_patterns();
        logic [7:0] pats [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h01, 8'h80};
        foreach (pats[i]) begin
            send_frame(pats[i], 0, 0, 0, 1);
            check_head("R2 data LSB first", 1, pats[i], 0, 0, 0);
            pop_one();
            check_head("R9 empty after pop", 0, 8'h00, 0, 0, 0);
        end
    endtask

    task automatic t_glitch();
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        check_head("R1 short low rejected", 0, 8'h00, 0, 0, 0);
        send_frame(8'h5A, 0, 0, 0, 1);
        check_head("R1 frame after glitch", 1, 8'h5A, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_parity();
        send_frame(8'h37, 1, 0, 0, 1);
        check_head("R3 even parity good", 1, 8'h37, 0, 0, 0);
        pop_one();
        send_frame(8'h37, 1, 0, 1, 1);
        check_head("R3 even parity bad", 1, 8'h37, 0, 1, 0);
        pop_one();
        send_frame(8'hC4, 1, 1, 0, 1);
        check_head("R3 odd parity good", 1, 8'hC4, 0, 0, 0);
        pop_one();
        send_frame(8'hC4, 1, 1, 1, 1);
        check_head("R3 odd parity bad", 1, 8'hC4, 0, 1, 0);
        pop_one();
        send_frame(8'h96, 0, 0, 0, 1);
        check_head("R8 clean after parity error", 1, 8'h96, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_par_latch();
        par_en  = 1'b0;
        par_odd = 1'b0;
        send_bit(1'b0);
        send_bit(1'b1);
        par_en = 1'b1;
        send_bit(1'b1);
        for (int i = 2; i < 8; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        check_head("R3 enable captured at start", 1, 8'h03, 0, 0, 0);
        pop_one();
        par_en = 1'b0;
    endtask

    task automatic t_frame();
        send_frame(8'hE1, 0, 0, 0, 0);
        check_head("R4 low stop bit", 1, 8'hE1, 1, 0, 0);
        pop_one();
        send_frame(8'h1E, 0, 0, 0, 1);
        check_head("R8 clean after frame error", 1, 8'h1E, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_stuck_low();
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(i[0]);
        repeat (4) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        check_head("R5 one char from stuck line", 1, 8'hAA, 1, 0, 0);
        pop_one();
        check_head("R5 no repeat while low", 0, 8'h00, 0, 0, 0);
        send_frame(8'h81, 0, 0, 0, 1);
        check_head("R5 receive after line high", 1, 8'h81, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_two_slots();
        pop_one();
        check_head("R10 pop on empty", 0, 8'h00, 0, 0, 0);
        send_frame(8'h11, 0, 0, 0, 1);
        send_frame(8'h22, 1, 0, 1, 1);
        check_head("R6 first of two", 1, 8'h11, 0, 0, 0);
        pop_one();
        check_head("R6 second with its flag", 1, 8'h22, 0, 1, 0);
        pop_one();
        check_head("R6 drained", 0, 8'h00, 0, 0, 0);
        pop_one();
        send_frame(8'h33, 0, 0, 0, 1);
        check_head("R10 order kept after empty pop", 1, 8'h33, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_overrun();
        send_frame(8'hA1, 0, 0, 0, 0);
        send_frame(8'hB2, 0, 0, 0, 1);
        send_frame(8'hC3, 0, 0, 0, 1);
        send_frame(8'hD4, 0, 0, 0, 1);
        check_head("R7 oldest kept", 1, 8'hA1, 1, 0, 0);
        pop_one();
        check_head("R7 second kept", 1, 8'hB2, 0, 0, 0);
        pop_one();
        check_head("R7 overrun marked", 1, 8'hD4, 0, 0, 1);
        pop_one();
        check_head("R7 queue empty", 0, 8'h00, 0, 0, 0);
        send_frame(8'h4E, 0, 0, 0, 1);
        check_head("R8 clean after overrun", 1, 8'h4E, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_hold_release();
        send_frame(8'h61, 0, 0, 0, 1);
        send_frame(8'h62, 0, 0, 0, 1);
        send_frame(8'h63, 0, 0, 0, 1);
        pop_one();
        check_head("R11 second at head", 1, 8'h62, 0, 0, 0);
        pop_one();
        check_head("R11 held char delivered", 1, 8'h63, 0, 0, 0);
        pop_one();
        check_head("R11 empty", 0, 8'h00, 0, 0, 0);
    endtask

    initial begin
        rst_n   = 1'b0;
        rx_line = 1'b1;
        par_en  = 1'b0;
        par_odd = 1'b0;
        rd_pop  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_patterns();
        t_glitch();
        t_parity();
        t_par_latch();
        t_frame();
        t_stuck_low();
        t_two_slots();
        t_overrun();
        t_hold_release();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule